// File: doc/BRIEF.md
# Speculative-Block L2 Fill Filter

This block is an admission controller placed between an L1 data cache and an exclusive L2 cache. A block that misses in both levels lives only in L1 and reaches L2 only when L1 evicts it. Each L1 victim carries two flags: whether it was fetched by a speculative load that later proved to be on a mispredicted path, and whether a correct-path access has touched it since. A speculative block that was never touched by a correct-path access may enter L2 only when its L2 set has a free way. Otherwise it goes to memory only. Every other victim is installed in L2.

The block also holds the L2 request queue, which is eight deep by default. Branch resolution sends kill pulses keyed by request tag, and each pulse marks the matching queued requests as wrong-path. When a marked request is dequeued, the controller drops it if its L2 set is full, or services it into an invalid line if the set has one. Every dequeued request returns a completion that reports whether it was dropped, so the requester can free its miss-tracking entry.

Top module: `spec_fill_filter`

## Requirements
- R1: A victim with `vic_spec`=0 produces, on the cycle after `vic_valid`, `l2_inst_valid`=1 with the victim's address and data and `mem_wr_valid`=0, whatever `vic_set_valid` shows.
- R2: A victim with `vic_spec`=1 and `vic_used`=1 is treated exactly like R1, even when every bit of `vic_set_valid` is 1.
- R3: A victim with `vic_spec`=1 and `vic_used`=0 whose `vic_set_valid` has at least one 0 bit (an invalid way) gives `l2_inst_valid`=1 and `mem_wr_valid`=0 on the next cycle.
- R4: A victim with `vic_spec`=1 and `vic_used`=0 whose `vic_set_valid` is all ones gives `mem_wr_valid`=1 with the victim's address and data, and `l2_inst_valid`=0, on the next cycle.
- R5: In the cycle after each victim, exactly one of `l2_inst_valid` and `mem_wr_valid` is high. Both are low in the cycle after a cycle with no victim.
- R6: Queued requests leave in arrival order. `head_tag` shows the oldest tag while `head_valid`=1. `req_full`=1 exactly when 8 requests are held. A dequeue happens in a cycle with `svc_ready`=1 and `head_valid`=1.
- R7: A dequeued request that has not been killed gives, on the next cycle, `done_valid`=1, `done_tag` equal to its tag, `done_drop`=0 and `done_fill_inv`=0, even if the set is full.
- R8: A killed request that is dequeued while `head_set_valid` is all ones completes on the next cycle with `done_drop`=1 and `done_fill_inv`=0.
- R9: A killed request that is dequeued while `head_set_valid` has a 0 bit completes with `done_drop`=0 and `done_fill_inv`=1.
- R10: A kill whose tag matches the head in the same cycle that the head is dequeued counts for that dequeue.
- R11: A kill marks only queued requests whose tag equals `kill_tag`. Requests with other tags complete as in R7.
- R12: After reset the queue is empty (`head_valid`=0, `req_full`=0), and `l2_inst_valid`, `mem_wr_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vic_valid | input | 1 | L1 victim present |
| vic_addr | input | AW | Victim block address |
| vic_data | input | DW | Victim block data |
| vic_spec | input | 1 | Victim was fetched by a wrong-path load |
| vic_used | input | 1 | Victim was touched by a correct-path access |
| vic_set_valid | input | WAYS | Valid bits of the victim's L2 set |
| l2_inst_valid | output | 1 | Install the victim in L2 |
| l2_inst_addr | output | AW | Install address |
| l2_inst_data | output | DW | Install data |
| mem_wr_valid | output | 1 | Write the victim to memory only |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| req_push | input | 1 | Enqueue an L2 request |
| req_tag | input | TW | Tag of the enqueued request |
| req_full | output | 1 | Queue holds DEPTH requests |
| kill_valid | input | 1 | Misprediction kill pulse |
| kill_tag | input | TW | Tag that the kill targets |
| head_valid | output | 1 | Queue is not empty |
| head_tag | output | TW | Tag of the oldest request |
| head_set_valid | input | WAYS | Valid bits of the head request's L2 set |
| svc_ready | input | 1 | L2 controller takes the head this cycle |
| done_valid | output | 1 | Completion of a dequeued request |
| done_tag | output | TW | Tag of the completed request |
| done_drop | output | 1 | Request was discarded without service |
| done_fill_inv | output | 1 | Wrong-path request was serviced into an invalid line |

## Verification
Two functions can fall in the same cycle: a kill pulse and the dequeue of the request it targets. The bench provokes this by raising `kill_valid` with the head's tag in the same cycle as `svc_ready`, with a full set, and expects `done_drop`=1 in the next cycle. A second case kills one tag while another request waits behind it, and then checks that only the killed request reports a drop. This shows that the mark is keyed on the tag and is not applied to the whole queue.

// File: rtl/spec_filter_pkg.sv
package spec_filter_pkg;

  // Set has at least one invalid way
  function automatic logic set_has_hole(input logic [31:0] vbits, input int ways);
    logic hole;
    hole = 1'b0;
    for (int w = 0; w < ways; w++) begin
      if (!vbits[w]) hole = 1'b1;
    end
    return hole;
  endfunction

  // Victim goes to L2 unless it is an untouched wrong-path block facing a full set
  function automatic logic victim_to_l2(input logic spec, input logic used, input logic hole);
    return !(spec && !used) || hole;
  endfunction

  typedef struct packed {
    logic drop;
    logic fill_inv;
  } verdict_t;

  function automatic verdict_t head_verdict(input logic wrong_path, input logic hole);
    verdict_t v;
    v.drop     = wrong_path && !hole;
    v.fill_inv = wrong_path && hole;
    return v;
  endfunction

endpackage

// File: rtl/sff_victim_admit.sv
module sff_victim_admit
  import spec_filter_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vic_valid,
  input  logic [AW-1:0]   vic_addr,
  input  logic [DW-1:0]   vic_data,
  input  logic            vic_spec,
  input  logic            vic_used,
  input  logic [WAYS-1:0] vic_set_valid,
  output logic            l2_inst_valid,
  output logic [AW-1:0]   l2_inst_addr,
  output logic [DW-1:0]   l2_inst_data,
  output logic            mem_wr_valid,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data
);

  logic [31:0] vbits_wide;
  logic        vic_hole;
  logic        admit_l2;

  assign vbits_wide = 32'(vic_set_valid);
  assign vic_hole   = set_has_hole(vbits_wide, WAYS);
  assign admit_l2   = victim_to_l2(vic_spec, vic_used, vic_hole);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l2_inst_valid <= 1'b0;
      mem_wr_valid  <= 1'b0;
      l2_inst_addr  <= '0;
      l2_inst_data  <= '0;
      mem_wr_addr   <= '0;
      mem_wr_data   <= '0;
    end else begin
      l2_inst_valid <= vic_valid && admit_l2;
      mem_wr_valid  <= vic_valid && !admit_l2;
      if (vic_valid && admit_l2) begin
        l2_inst_addr <= vic_addr;
        l2_inst_data <= vic_data;
      end
      if (vic_valid && !admit_l2) begin
        mem_wr_addr <= vic_addr;
        mem_wr_data <= vic_data;
      end
    end
  end

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |=> $onehot({l2_inst_valid, mem_wr_valid})); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_valid |=> !(l2_inst_valid || mem_wr_valid)); // R5
  AST_CP_TO_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && (!vic_spec || vic_used)) |=> l2_inst_valid); // R1
  AST_WP_FULL_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_spec && !vic_used && (&vic_set_valid)) |=> mem_wr_valid); // R4

endmodule

// File: rtl/sff_req_queue.sv
module sff_req_queue #(
  parameter int TW    = 6,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  input  logic          kill_valid,
  input  logic [TW-1:0] kill_tag,
  output logic          head_valid,
  output logic [TW-1:0] head_tag,
  output logic          head_wp,
  output logic          full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TW-1:0] ent_tag [DEPTH];
  logic          ent_wp  [DEPTH];
  logic          ent_vld [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CW'(DEPTH));
  assign head_valid = (count != '0);
  assign do_push    = push && !full;
  assign do_pop     = pop && head_valid;
  assign head_tag   = ent_tag[rd_ptr];
  assign head_wp    = ent_wp[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit_kill;
    assign hit_kill = kill_valid && ent_vld[i] && (ent_tag[i] == kill_tag);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[i] <= 1'b0;
        ent_wp[i]  <= 1'b0;
        ent_tag[i] <= '0;
      end else if (do_push && (wr_ptr == PW'(i))) begin
        ent_vld[i] <= 1'b1;
        ent_wp[i]  <= 1'b0;
        ent_tag[i] <= push_tag;
      end else if (do_pop && (rd_ptr == PW'(i))) begin
        ent_vld[i] <= 1'b0;
        ent_wp[i]  <= 1'b0;
      end else if (hit_kill) begin
        ent_wp[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_HEAD_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid |-> ent_vld[rd_ptr]); // R6
  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> head_valid); // R6

endmodule

// File: rtl/sff_head_screen.sv
module sff_head_screen
  import spec_filter_pkg::*;
#(
  parameter int TW   = 6,
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  input  logic [TW-1:0]   head_tag,
  input  logic            head_wp,
  input  logic            kill_valid,
  input  logic [TW-1:0]   kill_tag,
  input  logic [WAYS-1:0] head_set_valid,
  output logic            done_valid,
  output logic [TW-1:0]   done_tag,
  output logic            done_drop,
  output logic            done_fill_inv
);

  logic     late_kill;
  logic     wrong_path;
  logic     head_hole;
  verdict_t vd;

  assign late_kill  = kill_valid && (kill_tag == head_tag);
  assign wrong_path = head_wp || late_kill;
  assign head_hole  = set_has_hole(32'(head_set_valid), WAYS);
  assign vd         = head_verdict(wrong_path, head_hole);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid    <= 1'b0;
      done_tag      <= '0;
      done_drop     <= 1'b0;
      done_fill_inv <= 1'b0;
    end else begin
      done_valid    <= pop;
      done_tag      <= pop ? head_tag : done_tag;
      done_drop     <= pop && vd.drop;
      done_fill_inv <= pop && vd.fill_inv;
    end
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_drop && done_fill_inv)); // R9
  AST_POP_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> done_valid); // R7
  AST_LATE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && late_kill && (&head_set_valid)) |=> done_drop); // R10
  AST_CLEAN_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wrong_path) |=> !(done_drop || done_fill_inv)); // R7

endmodule

// File: rtl/spec_fill_filter.sv
module spec_fill_filter
  import spec_filter_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int WAYS  = 4,
  parameter int TW    = 6,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vic_valid,
  input  logic [AW-1:0]   vic_addr,
  input  logic [DW-1:0]   vic_data,
  input  logic            vic_spec,
  input  logic            vic_used,
  input  logic [WAYS-1:0] vic_set_valid,
  output logic            l2_inst_valid,
  output logic [AW-1:0]   l2_inst_addr,
  output logic [DW-1:0]   l2_inst_data,
  output logic            mem_wr_valid,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data,
  input  logic            req_push,
  input  logic [TW-1:0]   req_tag,
  output logic            req_full,
  input  logic            kill_valid,
  input  logic [TW-1:0]   kill_tag,
  output logic            head_valid,
  output logic [TW-1:0]   head_tag,
  input  logic [WAYS-1:0] head_set_valid,
  input  logic            svc_ready,
  output logic            done_valid,
  output logic [TW-1:0]   done_tag,
  output logic            done_drop,
  output logic            done_fill_inv
);

  logic q_pop;
  logic q_head_wp;

  assign q_pop = svc_ready && head_valid;

  sff_victim_admit #(.AW(AW), .DW(DW), .WAYS(WAYS)) u_admit (
    .clk(clk), .rst_n(rst_n),
    .vic_valid(vic_valid), .vic_addr(vic_addr), .vic_data(vic_data),
    .vic_spec(vic_spec), .vic_used(vic_used), .vic_set_valid(vic_set_valid),
    .l2_inst_valid(l2_inst_valid), .l2_inst_addr(l2_inst_addr), .l2_inst_data(l2_inst_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  sff_req_queue #(.TW(TW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(req_push), .push_tag(req_tag), .pop(q_pop),
    .kill_valid(kill_valid), .kill_tag(kill_tag),
    .head_valid(head_valid), .head_tag(head_tag), .head_wp(q_head_wp),
    .full(req_full)
  );

  sff_head_screen #(.TW(TW), .WAYS(WAYS)) u_screen (
    .clk(clk), .rst_n(rst_n),
    .pop(q_pop), .head_tag(head_tag), .head_wp(q_head_wp),
    .kill_valid(kill_valid), .kill_tag(kill_tag), .head_set_valid(head_set_valid),
    .done_valid(done_valid), .done_tag(done_tag),
    .done_drop(done_drop), .done_fill_inv(done_fill_inv)
  );

  AST_DONE_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(q_pop)); // R7

endmodule

// File: tb/sim_spec_fill_filter.sv
module sim_spec_fill_filter;
  localparam int AW = 32, DW = 64, WAYS = 4, TW = 6, DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vic_valid = 0, vic_spec = 0, vic_used = 0;
  logic [AW-1:0] vic_addr = '0;
  logic [DW-1:0] vic_data = '0;
  logic [WAYS-1:0] vic_set_valid = '0;
  logic l2_inst_valid, mem_wr_valid;
  logic [AW-1:0] l2_inst_addr, mem_wr_addr;
  logic [DW-1:0] l2_inst_data, mem_wr_data;
  logic req_push = 0, kill_valid = 0, svc_ready = 0;
  logic [TW-1:0] req_tag = '0, kill_tag = '0;
  logic [WAYS-1:0] head_set_valid = '0;
  logic req_full, head_valid, done_valid, done_drop, done_fill_inv;
  logic [TW-1:0] head_tag, done_tag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spec_fill_filter #(.AW(AW), .DW(DW), .WAYS(WAYS), .TW(TW), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_victim(input string req, input logic spec, input logic used,
                             input logic [WAYS-1:0] setv, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input logic exp_l2);
    @(negedge clk);
    vic_valid = 1; vic_spec = spec; vic_used = used; vic_set_valid = setv;
    vic_addr = a; vic_data = d;
    @(negedge clk);
    vic_valid = 0;
    chk(req, "l2_inst_valid", l2_inst_valid, exp_l2);
    chk(req, "mem_wr_valid", mem_wr_valid, !exp_l2);
    if (exp_l2) begin
      chk(req, "l2_inst_addr", l2_inst_addr, a);
      chk(req, "l2_inst_data", l2_inst_data, d);
    end else begin
      chk(req, "mem_wr_addr", mem_wr_addr, a);
      chk(req, "mem_wr_data", mem_wr_data, d);
    end
  endtask

  task automatic push(input logic [TW-1:0] t);
    @(negedge clk);
    req_push = 1; req_tag = t;
    @(negedge clk);
    req_push = 0;
  endtask

  task automatic kill(input logic [TW-1:0] t);
    @(negedge clk);
    kill_valid = 1; kill_tag = t;
    @(negedge clk);
    kill_valid = 0;
  endtask

  task automatic pop(input string req, input logic [TW-1:0] exp_tag, input logic [WAYS-1:0] setv,
                     input logic kill_now, input logic exp_drop, input logic exp_fill);
    @(negedge clk);
    chk(req, "head_valid", head_valid, 1);
    chk(req, "head_tag", head_tag, exp_tag);
    svc_ready = 1; head_set_valid = setv;
    if (kill_now) begin kill_valid = 1; kill_tag = exp_tag; end
    @(negedge clk);
    svc_ready = 0; kill_valid = 0;
    chk(req, "done_valid", done_valid, 1);
    chk(req, "done_tag", done_tag, exp_tag);
    chk(req, "done_drop", done_drop, exp_drop);
    chk(req, "done_fill_inv", done_fill_inv, exp_fill);
  endtask

  task automatic t_reset();
    chk("R12", "head_valid", head_valid, 0);
    chk("R12", "req_full", req_full, 0);
    chk("R12", "l2_inst_valid", l2_inst_valid, 0);
    chk("R12", "mem_wr_valid", mem_wr_valid, 0);
    chk("R12", "done_valid", done_valid, 0);
  endtask

  task automatic t_victims();
    send_victim("R1", 0, 0, 4'b1111, 32'h1000, 64'hA1, 1);
    send_victim("R1", 0, 0, 4'b0000, 32'h1040, 64'hA2, 1);
    send_victim("R2", 1, 1, 4'b1111, 32'h2000, 64'hB1, 1);
    send_victim("R3", 1, 0, 4'b1011, 32'h3000, 64'hC1, 1);
    send_victim("R3", 1, 0, 4'b0111, 32'h3040, 64'hC2, 1);
    send_victim("R4", 1, 0, 4'b1111, 32'h4000, 64'hD1, 0);
    @(negedge clk);
    chk("R5", "idle l2_inst_valid", l2_inst_valid, 0);
    chk("R5", "idle mem_wr_valid", mem_wr_valid, 0);
  endtask

  task automatic t_fifo();
    for (int i = 0; i < DEPTH; i++) push(TW'(i + 10));
    chk("R6", "req_full", req_full, 1);
    for (int i = 0; i < DEPTH; i++) pop("R7", TW'(i + 10), 4'b1111, 0, 0, 0);
    chk("R6", "empty head_valid", head_valid, 0);
    chk("R6", "req_full after drain", req_full, 0);
  endtask

  task automatic t_kill_full();
    push(6'd33);
    kill(6'd33);
    pop("R8", 6'd33, 4'b1111, 0, 1, 0);
  endtask

  task automatic t_kill_hole();
    push(6'd34);
    kill(6'd34);
    pop("R9", 6'd34, 4'b1101, 0, 0, 1);
  endtask

  task automatic t_kill_same_cycle();
    push(6'd35);
    pop("R10", 6'd35, 4'b1111, 1, 1, 0);
  endtask

  task automatic t_kill_selective();
    push(6'd40);
    push(6'd41);
    push(6'd42);
    kill(6'd41);
    pop("R11", 6'd40, 4'b1111, 0, 0, 0);
    pop("R11", 6'd41, 4'b1111, 0, 1, 0);
    pop("R11", 6'd42, 4'b1111, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_victims();
    t_fifo();
    t_kill_full();
    t_kill_hole();
    t_kill_same_cycle();
    t_kill_selective();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule